// File: doc/BRIEF.md
# Interrupt Ring Buffer Writer

Internal engines raise interrupts by handing this block a request that carries a client id, a source id, a ring id and a context value. The block queues these requests and serves them one at a time, in the order they arrived. For each request it builds a 32-byte record of eight 32-bit words. It stores the record in a ring buffer in host memory. It then advances its write offset and stores the new offset at a host-visible pointer location. Only after that does it pulse an interrupt line towards the host.

The host configures the block through a write-only register port. The registers set the ring base, the pointer location and the write offset, and they carry a doorbell setting that is handed on to a neighbouring router as a strobe. Memory traffic leaves through a valid/ready master port. Each beat on that port is one 32-bit word with a 64-bit physical byte address. The host consumes records and moves its read pointer without involving this block.

Top module: `irq_ring_writer`

## Requirements
- R1: Each record is sent as eight consecutive accepted beats whose addresses are ring base + write offset + 4*k for k = 0..7, in increasing k.
- R2: Record word 0 carries client id in bits 7:0, source id in bits 15:8 and ring id in bits 23:16. Bits 31:24 (VM id, reserved, VM id type) are zero.
- R3: Record word 1 is the constant 0x40, word 4 is the request's context value, and words 2, 3, 5, 6 and 7 are zero.
- R4: After the eighth record beat is accepted, the write offset becomes offset + 32, or zero when that sum reaches RING_BYTES. The next beat goes to the pointer address (high word at register 0x85, low word at register 0x86) and carries the new offset.
- R5: `hostIrq` is high for exactly one cycle, in the cycle after the pointer beat is accepted. No beat of the next record is issued before that pulse.
- R6: Register 0x81 sets ring base bits 31:0 to the written value shifted left by 8. Register 0x82 sets base bits 63:32. Every register write replaces its field completely.
- R7: A write to register 0x87 stores bits 25:0, and `dbOffset` shows that stored value shifted left by 2. If bit 28 of the written value is set, `dbEnStrobe` is high for the one cycle after the write. Otherwise it stays low.
- R8: Requests are served in arrival order. The queue holds QDEPTH requests beside the one being served, and `reqReady` is low while the queue is full.
- R9: A write to register 0x84 sets the write offset at once when the block is idle. While a record or pointer write is in progress, the write takes effect only after the current interrupt finishes.
- R10: Writes to register 0x80 (control), register 0x83 (read pointer) or any unmapped offset change neither the memory traffic nor any output.
- R11: While `memValid` is high and `memReady` is low, `memValid` stays high and `memAddr` and `memData` hold their values.
- R12: After reset, `memValid`, `hostIrq` and `dbEnStrobe` are low, `reqReady` is high, and the write offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word offset |
| regWrData | input | 32 | Register write value |
| reqValid | input | 1 | Interrupt request valid |
| reqReady | output | 1 | Request queue has room |
| reqClient | input | 8 | Requesting client id |
| reqSource | input | 8 | Source id |
| reqRing | input | 8 | Ring id |
| reqCtx | input | 32 | Context value placed in record word 4 |
| memValid | output | 1 | Memory write beat valid |
| memReady | input | 1 | Memory accepts the beat |
| memAddr | output | 64 | Physical byte address of the beat |
| memData | output | 32 | Beat data word |
| hostIrq | output | 1 | One-cycle interrupt pulse to the host |
| dbEnStrobe | output | 1 | Doorbell enable strobe |
| dbOffset | output | 28 | Stored doorbell offset shifted left by 2 |

## Verification
A sweep sends a dozen requests whose ids and context values are derived from their index, so that any swapped, shifted or dropped field in word 0 or word 4 shows up. Memory readiness follows a pseudo-random pattern, and the sweep covers more than one lap of the ring, so the wrap to offset zero and the hold-under-backpressure behaviour both occur. A second group starts from a host-written offset near the end of the ring, which separates an immediate offset load from a late one and hits the wrap on its last record. A stall phase holds memory ready low. This fills the queue, counts exactly how many requests are accepted, and writes a new offset mid-record, which shows whether the write is deferred to the following record. Register tests write a junk value first and then the real one, which tells a full replace from an OR-accumulate, and they drive the doorbell with bit 28 both set and clear.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int REC_DWORDS = 8;
  localparam int REC_BYTES  = REC_DWORDS * 4;
  localparam int BEAT_W     = $clog2(REC_DWORDS);
  localparam int MEM_AW     = 64;
  localparam int REG_AW     = 8;
  localparam int DB_KEEP_W  = 26;
  localparam int DB_EN_BIT  = 28;
  localparam int DB_OUT_W   = DB_KEEP_W + 2;

  localparam logic [31:0] STAMP_LO = 32'h0000_0040;

  // register word offsets
  localparam logic [REG_AW-1:0] OFS_CTRL     = 8'h80;
  localparam logic [REG_AW-1:0] OFS_BASE_LO  = 8'h81;
  localparam logic [REG_AW-1:0] OFS_BASE_HI  = 8'h82;
  localparam logic [REG_AW-1:0] OFS_RPTR     = 8'h83;
  localparam logic [REG_AW-1:0] OFS_WPTR     = 8'h84;
  localparam logic [REG_AW-1:0] OFS_WPA_HI   = 8'h85;
  localparam logic [REG_AW-1:0] OFS_WPA_LO   = 8'h86;
  localparam logic [REG_AW-1:0] OFS_DOORBELL = 8'h87;

  typedef struct packed {
    logic [7:0]  clientId;
    logic [7:0]  sourceId;
    logic [7:0]  ringId;
    logic [31:0] ctxId;
  } irqReq_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;      // take queue head as current request
    logic beatAdv;   // a record beat was accepted
    logic recDone;   // last record beat accepted
    logic ptrPhase;  // pointer beat is on the bus
    logic finish;    // interrupt pulse cycle
  } seqStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECORD,
    ST_POINTER,
    ST_SIGNAL
  } seqState_t;
endpackage

// File: rtl/irw_fifo.sv
module irw_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 56
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] popData,
  output logic          empty,
  output logic          full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign popData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (!full || pop));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/irw_ctrl.sv
module irw_ctrl
  import irw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     qEmpty,
  input  logic     lastBeat,
  input  logic     memReady,
  output seqStrb_t strb,
  output logic     memValid,
  output logic     hostIrq,
  output logic     holdWptr
);
  seqState_t state;
  seqState_t stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    memValid = 1'b0;
    hostIrq  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!qEmpty) begin
          strb.load = 1'b1;
          stateNxt  = ST_RECORD;
        end
      end
      ST_RECORD: begin
        memValid = 1'b1;
        if (memReady) begin
          strb.beatAdv = 1'b1;
          if (lastBeat) begin
            strb.recDone = 1'b1;
            stateNxt     = ST_POINTER;
          end
        end
      end
      ST_POINTER: begin
        memValid      = 1'b1;
        strb.ptrPhase = 1'b1;
        if (memReady) stateNxt = ST_SIGNAL;
      end
      ST_SIGNAL: begin
        hostIrq     = 1'b1;
        strb.finish = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // offset writes are deferred while a record or pointer write is in flight
  assign holdWptr = (state == ST_RECORD) || (state == ST_POINTER);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq);
  assert_irq_after_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(memValid && memReady && strb.ptrPhase));
  assert_valid_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);
endmodule

// File: rtl/irw_datapath.sv
module irw_datapath
  import irw_pkg::*;
#(
  parameter int RING_BYTES = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  input  seqStrb_t            strb,
  input  logic                holdWptr,
  input  irqReq_t             head,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [31:0]         memData,
  output logic                lastBeat,
  output logic                dbEnStrobe,
  output logic [DB_OUT_W-1:0] dbOffset
);
  logic [31:0]          baseLo, baseHi, wpaLo, wpaHi;
  logic [31:0]          wrOff, pendVal, nextOff;
  logic                 pendValid;
  logic [DB_KEEP_W-1:0] dbReg;
  logic                 dbStb;
  irqReq_t              cur;
  logic [BEAT_W-1:0]    beat;
  logic [31:0]          recWords [REC_DWORDS];
  logic [32:0]          offSum;
  logic                 selBaseLo, selBaseHi, selWptr, selWpaHi, selWpaLo, selDb;

  // register decode; control and read pointer are accepted and dropped
  always_comb begin
    {selBaseLo, selBaseHi, selWptr, selWpaHi, selWpaLo, selDb} = '0;
    if (regWrEn) begin
      unique case (regAddr)
        OFS_BASE_LO:      selBaseLo = 1'b1;
        OFS_BASE_HI:      selBaseHi = 1'b1;
        OFS_WPTR:         selWptr   = 1'b1;
        OFS_WPA_HI:       selWpaHi  = 1'b1;
        OFS_WPA_LO:       selWpaLo  = 1'b1;
        OFS_DOORBELL:     selDb     = 1'b1;
        OFS_CTRL, OFS_RPTR: ;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo <= '0;
      baseHi <= '0;
      wpaLo  <= '0;
      wpaHi  <= '0;
      dbReg  <= '0;
      dbStb  <= 1'b0;
    end else begin
      if (selBaseLo) baseLo <= regWrData << 8;
      if (selBaseHi) baseHi <= regWrData;
      if (selWpaLo)  wpaLo  <= regWrData;
      if (selWpaHi)  wpaHi  <= regWrData;
      if (selDb)     dbReg  <= regWrData[DB_KEEP_W-1:0];
      dbStb <= selDb && regWrData[DB_EN_BIT];
    end
  end

  assign dbEnStrobe = dbStb;
  assign dbOffset   = {dbReg, 2'b00};

  // write offset with wrap and deferred host update
  assign offSum  = {1'b0, wrOff} + 33'(REC_BYTES);
  assign nextOff = (offSum >= 33'(RING_BYTES)) ? '0 : offSum[31:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrOff     <= '0;
      pendValid <= 1'b0;
      pendVal   <= '0;
    end else begin
      if (strb.recDone) wrOff <= nextOff;
      if (selWptr && !holdWptr)          wrOff <= regWrData;
      else if (strb.finish && pendValid) wrOff <= pendVal;

      if (selWptr && holdWptr) begin
        pendValid <= 1'b1;
        pendVal   <= regWrData;
      end else if (strb.finish) begin
        pendValid <= 1'b0;
      end
    end
  end

  // current request and beat index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur  <= '0;
      beat <= '0;
    end else begin
      if (strb.load) begin
        cur  <= head;
        beat <= '0;
      end else if (strb.beatAdv) begin
        beat <= beat + 1'b1;
      end
    end
  end

  assign lastBeat = (beat == BEAT_W'(REC_DWORDS - 1));

  // record image; VM id, VM id type and reserved bits are zero
  always_comb begin
    for (int i = 0; i < REC_DWORDS; i++) recWords[i] = '0;
    recWords[0] = {8'h00, cur.ringId, cur.sourceId, cur.clientId};
    recWords[1] = STAMP_LO;
    recWords[4] = cur.ctxId;
  end

  always_comb begin
    if (strb.ptrPhase) begin
      memAddr = {wpaHi, wpaLo};
      memData = wrOff;
    end else begin
      memAddr = {baseHi, baseLo} + {32'h0, wrOff} + MEM_AW'({beat, 2'b00});
      memData = recWords[beat];
    end
  end

  assert_db_strobe_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    dbEnStrobe |-> $past(regWrEn && regAddr == OFS_DOORBELL && regWrData[DB_EN_BIT]));
  assert_ptr_after_record_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.ptrPhase) |-> $past(strb.recDone));
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
  import irw_pkg::*;
#(
  parameter int QDEPTH     = 4,
  parameter int RING_BYTES = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [7:0]          reqClient,
  input  logic [7:0]          reqSource,
  input  logic [7:0]          reqRing,
  input  logic [31:0]         reqCtx,
  output logic                memValid,
  input  logic                memReady,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [31:0]         memData,
  output logic                hostIrq,
  output logic                dbEnStrobe,
  output logic [DB_OUT_W-1:0] dbOffset
);
  localparam int REQ_W = $bits(irqReq_t);

  seqStrb_t strb;
  irqReq_t  inReq, headReq;
  logic     qEmpty, qFull, push, lastBeat, holdWptr;

  assign inReq    = '{clientId: reqClient, sourceId: reqSource, ringId: reqRing, ctxId: reqCtx};
  assign reqReady = !qFull;
  assign push     = reqValid && reqReady;

  irw_fifo #(.DEPTH(QDEPTH), .DW(REQ_W)) u_queue (
    .clk      (clk),
    .rstN     (rstN),
    .push     (push),
    .pushData (inReq),
    .pop      (strb.load),
    .popData  (headReq),
    .empty    (qEmpty),
    .full     (qFull)
  );

  irw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .qEmpty   (qEmpty),
    .lastBeat (lastBeat),
    .memReady (memReady),
    .strb     (strb),
    .memValid (memValid),
    .hostIrq  (hostIrq),
    .holdWptr (holdWptr)
  );

  irw_datapath #(.RING_BYTES(RING_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strb       (strb),
    .holdWptr   (holdWptr),
    .head       (headReq),
    .memAddr    (memAddr),
    .memData    (memData),
    .lastBeat   (lastBeat),
    .dbEnStrobe (dbEnStrobe),
    .dbOffset   (dbOffset)
  );

  assert_data_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memData)));
endmodule

// File: tb/irq_ring_writer_bench.sv
`timescale 1ns/100ps
module irq_ring_writer_bench;
  localparam int QD = 4;
  localparam int RB = 256;
  localparam int MAXR = 32;
  localparam int MAXB = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqClient = '0, reqSource = '0, reqRing = '0;
  logic [31:0] reqCtx = '0;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [63:0] memAddr;
  logic [31:0] memData;
  logic        hostIrq, dbEnStrobe;
  logic [27:0] dbOffset;

  irq_ring_writer #(.QDEPTH(QD), .RING_BYTES(RB)) u_irq_ring_writer (.*);

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  int readyMode = 0;            // 0 stall, 1 pseudo-random, 2 always
  logic [15:0] lfsr = 16'hACE1;

  // expected-model storage
  int reqCnt = 0;
  logic [7:0]  mClient [MAXR];
  logic [7:0]  mSource [MAXR];
  logic [7:0]  mRing   [MAXR];
  logic [31:0] mCtx    [MAXR];
  bit          ovrV    [MAXR];
  logic [31:0] ovrVal  [MAXR];
  logic [63:0] expBase, expWpa;

  // observed traffic
  int beatCnt = 0, irqCount = 0;
  logic [63:0] logAddr [MAXB];
  logic [31:0] logData [MAXB];
  int          irqBeat [MAXR];
  bit          prevStall = 1'b0;
  logic [63:0] prevAddr;
  logic [31:0] prevData;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (readyMode)
      0: memReady <= 1'b0;
      1: memReady <= lfsr[0] | lfsr[3];
      default: memReady <= 1'b1;
    endcase
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin  // R11 hold under backpressure
        chk(memValid == 1'b1, "R11 valid held", 64'(memValid), 64'd1);
        chk(memAddr == prevAddr, "R11 addr held", memAddr, prevAddr);
        chk(memData == prevData, "R11 data held", 64'(memData), 64'(prevData));
      end
      prevStall = memValid && !memReady;
      prevAddr  = memAddr;
      prevData  = memData;
      if (memValid && memReady && beatCnt < MAXB) begin
        logAddr[beatCnt] = memAddr;
        logData[beatCnt] = memData;
        beatCnt++;
      end
      if (hostIrq && irqCount < MAXR) begin
        irqBeat[irqCount] = beatCnt;
        irqCount++;
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic store(input logic [7:0] c, s, r, input logic [31:0] x);
    mClient[reqCnt] = c; mSource[reqCnt] = s; mRing[reqCnt] = r; mCtx[reqCnt] = x;
    reqCnt++;
  endtask

  task automatic pushReq(input logic [7:0] c, s, r, input logic [31:0] x);
    @(negedge clk);
    reqValid = 1'b1; reqClient = c; reqSource = s; reqRing = r; reqCtx = x;
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 1'b0;
    store(c, s, r, x);
  endtask

  task automatic tryPush(input logic [7:0] c, s, r, input logic [31:0] x, output bit acc);
    @(negedge clk);
    reqValid = 1'b1; reqClient = c; reqSource = s; reqRing = r; reqCtx = x;
    acc = reqReady;
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (acc) store(c, s, r, x);
  endtask

  task automatic drain();
    while (irqCount < reqCnt) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verifyAll();
    logic [31:0] off, nOff, expW;
    int b;
    off = 32'h0;
    chk(beatCnt == reqCnt * 9, "R1 total beats", 64'(beatCnt), 64'(reqCnt * 9));
    chk(irqCount == reqCnt, "R5 interrupt count", 64'(irqCount), 64'(reqCnt));
    for (int r = 0; r < reqCnt; r++) begin
      if (ovrV[r]) off = ovrVal[r];
      nOff = (off + 32 >= RB) ? 32'h0 : off + 32;
      for (int k = 0; k < 8; k++) begin
        b = r * 9 + k;
        chk(logAddr[b] == expBase + 64'(off) + 64'(4 * k), "R1 record beat address",
            logAddr[b], expBase + 64'(off) + 64'(4 * k));
        case (k)
          0: expW = {8'h00, mRing[r], mSource[r], mClient[r]};
          1: expW = 32'h40;
          4: expW = mCtx[r];
          default: expW = 32'h0;
        endcase
        chk(logData[b] == expW, (k == 0) ? "R2 word0 layout" : "R3 record word",
            64'(logData[b]), 64'(expW));
      end
      b = r * 9 + 8;
      chk(logAddr[b] == expWpa, "R4 pointer address", logAddr[b], expWpa);
      chk(logData[b] == nOff, "R4 pointer value/wrap", 64'(logData[b]), 64'(nOff));
      chk(irqBeat[r] == r * 9 + 9, "R5 irq after pointer", 64'(irqBeat[r]), 64'(r * 9 + 9));
      off = nOff;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    bit acc;
    int accepted, stallIdx;
    logic [31:0] d;
    for (int i = 0; i < MAXR; i++) begin ovrV[i] = 1'b0; ovrVal[i] = '0; end

    // R12 reset state
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R12 reqReady", 64'(reqReady), 64'd1);
    chk(memValid == 1'b0, "R12 memValid", 64'(memValid), 64'd0);
    chk(hostIrq == 1'b0, "R12 hostIrq", 64'(hostIrq), 64'd0);
    chk(dbEnStrobe == 1'b0, "R12 dbEnStrobe", 64'(dbEnStrobe), 64'd0);

    // R6 configuration with full replace
    regWrite(8'h81, 32'hFFFF_FFFF);
    regWrite(8'h81, 32'h0000_0123);
    regWrite(8'h82, 32'hFFFF_FFFF);
    regWrite(8'h82, 32'h0000_0001);
    regWrite(8'h86, 32'hFFFF_FFFF);
    regWrite(8'h86, 32'h0000_5000);
    regWrite(8'h85, 32'hFFFF_FFFF);
    regWrite(8'h85, 32'h0000_0002);
    expBase = {32'h1, 32'h0000_0123 << 8};
    expWpa  = {32'h2, 32'h0000_5000};

    // R10 writes with no effect
    regWrite(8'h80, 32'hFFFF_FFFF);
    regWrite(8'h83, 32'h0000_00E0);
    regWrite(8'h88, 32'h1FFF_FFFF);
    regWrite(8'h7F, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!memValid && !hostIrq && !dbEnStrobe, "R10 no activity",
          {61'h0, memValid, hostIrq, dbEnStrobe}, 64'h0);
    end

    // R7 doorbell with enable bit set, then clear
    d = 32'hF3AB_CDEF;
    regWrite(8'h87, d);
    chk(dbEnStrobe == 1'b1, "R7 strobe on enable", 64'(dbEnStrobe), 64'd1);
    chk(dbOffset == 28'((d & 32'h03FF_FFFF) << 2), "R7 offset",
        64'(dbOffset), 64'((d & 32'h03FF_FFFF) << 2));
    @(negedge clk);
    chk(dbEnStrobe == 1'b0, "R7 strobe single cycle", 64'(dbEnStrobe), 64'd0);
    d = 32'h0C00_1234;
    regWrite(8'h87, d);
    chk(dbEnStrobe == 1'b0, "R7 no strobe without enable", 64'(dbEnStrobe), 64'd0);
    chk(dbOffset == 28'((d & 32'h03FF_FFFF) << 2), "R7 offset update",
        64'(dbOffset), 64'((d & 32'h03FF_FFFF) << 2));

    // R1 R2 R3 R4 R8 sweep across more than one ring lap
    readyMode = 1;
    for (int i = 0; i < 12; i++)
      pushReq(8'((i * 37 + 5) & 255), 8'((i * 53 + 200) & 255), 8'(255 - i * 11),
              32'h9000_0000 ^ (32'(i) * 32'h0101_0101));
    drain();

    // R9 immediate offset load while idle, wraps on third record
    regWrite(8'h84, 32'h0000_00A0);
    ovrV[reqCnt] = 1'b1; ovrVal[reqCnt] = 32'h0000_00A0;
    readyMode = 2;
    for (int i = 0; i < 3; i++)
      pushReq(8'hFF, 8'h00, 8'(i), 32'hFFFF_FFFF - 32'(i));
    drain();

    // R8 queue fill under stall, R9 deferred offset write
    readyMode = 0;
    repeat (2) @(negedge clk);
    stallIdx = reqCnt;
    accepted = 0;
    for (int i = 0; i < QD + 2; i++) begin
      tryPush(8'(i + 1), 8'(i + 16), 8'(i + 32), 32'h5A5A_0000 + 32'(i), acc);
      if (acc) accepted++;
    end
    chk(accepted == QD + 1, "R8 accepted while stalled", 64'(accepted), 64'(QD + 1));
    chk(reqReady == 1'b0, "R8 ready low when full", 64'(reqReady), 64'd0);
    regWrite(8'h84, 32'h0000_0060);
    ovrV[stallIdx + 1] = 1'b1; ovrVal[stallIdx + 1] = 32'h0000_0060;
    readyMode = 1;
    drain();

    verifyAll();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule